// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block takes one interprocessor interrupt command and the index of the unit that issued it, and works out which of `N_TGT` target units should take the interrupt. Each target presents a 32-bit identity word, with its physical ID in the top byte, an 8-bit logical ID, a 2-bit destination-format code and an enable flag. The command can address targets physically, through flat logical addressing or through cluster logical addressing. A two-bit shorthand can override the destination field and select the sender only, every target, or every target except the sender.

For every delivery mode except lowest priority, the result is the full mask of matching targets. In lowest-priority mode, the matching and enabled targets form a candidate set, and exactly one of them is chosen by a round-robin pointer that persists across commands. The result is registered. It appears one cycle after the command strobe, together with a one-cycle done pulse. The block does not record the interrupt in the targets and has no transport of its own.

Top module: `ipi_dest_match`

## Requirements
- R1: With shorthand 00, delivery mode other than 001, and destination-mode bit (`cmd_lo_i[11]`) clear, target i is selected when the destination byte `cmd_hi_i[31:24]` equals 0xFF or equals bits 31:24 of that target's identity word. The other identity bits are ignored.
- R2: With shorthand 00 and `cmd_lo_i[11]` set, a target with format code 00 (flat) is selected when its logical ID AND the destination byte is nonzero.
- R3: With shorthand 00 and `cmd_lo_i[11]` set, a target with format code 01 (cluster) is selected when the upper nibble of its logical ID equals the upper nibble of the destination byte and the AND of the two lower nibbles is nonzero.
- R4: The shorthand `cmd_lo_i[19:18]` decodes as follows. 00 uses the destination field. 01 selects only the target whose index equals `src_idx_i`. 10 selects all targets. 11 selects all targets except `src_idx_i`.
- R5: In lowest-priority mode (delivery mode `cmd_lo_i[10:8]` = 001), the output mask has at most one bit set. That bit is the first target that both matches and is enabled, searching upward from one past the previous choice and wrapping around.
- R6: In lowest-priority mode with no target that both matches and is enabled, the mask is all zero and the round-robin pointer stays where it was.
- R7: In every delivery mode other than 001, the mask is the full match set regardless of `tgt_en_i`.
- R8: A target whose format code is 10 or 11 is never selected by a logical, no-shorthand command. Such a command sets `fmt_err_o`, which then stays set until reset.
- R9: `done_o` is high exactly in the cycle after a cycle with `cmd_valid_i` high. `deliver_o` is zero whenever `done_o` is low.
- R10: After reset, `done_o`, `deliver_o` and `fmt_err_o` are zero, and the round-robin pointer rests on the last target, so the first lowest-priority search starts at target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_lo_i | input | 32 | Low command word: delivery mode [10:8], destination mode [11], shorthand [19:18] |
| cmd_hi_i | input | 32 | High command word: destination byte [31:24] |
| src_idx_i | input | IDX_W | Index of the issuing unit |
| tgt_id_i | input | 32*N_TGT | Per-target identity words, physical ID in bits 31:24 of each word |
| tgt_log_id_i | input | 8*N_TGT | Per-target logical IDs |
| tgt_fmt_i | input | 2*N_TGT | Per-target format code: 00 flat, 01 cluster, other codes invalid |
| tgt_en_i | input | N_TGT | Per-target enable, used only for lowest-priority selection |
| deliver_o | output | N_TGT | Registered per-target delivery mask |
| done_o | output | 1 | Result-valid pulse |
| fmt_err_o | output | 1 | Sticky flag for an invalid format code |

## Verification
The hardest behaviour to reach from the ports is the persistent round-robin state. Its position is never visible, and each pick depends on the whole history of lowest-priority commands. The stimulus therefore starts from reset and issues a known chain of lowest-priority broadcasts, so that each grant shows where the pointer stands. It then thins the enable set so that the search must skip targets and wrap. After that, it removes every eligible target and then restores them all. The next grant shows that the empty search left the pointer where it was.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [1:0] FMT_FLAT    = 2'b00;
  localparam logic [1:0] FMT_CLUSTER = 2'b01;
  localparam logic [2:0] DM_LOWEST   = 3'b001;

  typedef struct packed {
    logic [7:0] dest;
    shorthand_e sh;
    logic       logical;
    logic [2:0] dmode;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] lo, input logic [31:0] hi);
    cmd_t c;
    c.dest    = hi[31:24];
    c.sh      = shorthand_e'(lo[19:18]);
    c.logical = lo[11];
    c.dmode   = lo[10:8];
    return c;
  endfunction
endpackage

// File: rtl/ipi_tgt_match.sv
module ipi_tgt_match
  import ipi_match_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int TGT_IDX = 0
) (
  input  cmd_t             cmd_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [7:0]       phys_id_i,
  input  logic [7:0]       log_id_i,
  input  logic [1:0]       fmt_i,
  output logic             hit_o,
  output logic             bad_fmt_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(TGT_IDX);

  always_comb begin
    hit_o     = 1'b0;
    bad_fmt_o = 1'b0;
    case (cmd_i.sh)
      SH_NONE: begin
        if (!cmd_i.logical) begin
          hit_o = (cmd_i.dest == 8'hFF) || (cmd_i.dest == phys_id_i);
        end else begin
          case (fmt_i)
            FMT_FLAT:    hit_o = |(log_id_i & cmd_i.dest);
            FMT_CLUSTER: hit_o = (log_id_i[7:4] == cmd_i.dest[7:4]) &&
                                 |(log_id_i[3:0] & cmd_i.dest[3:0]);
            default:     bad_fmt_o = 1'b1;
          endcase
        end
      end
      SH_SELF:   hit_o = (src_idx_i == MY_IDX);
      SH_ALL:    hit_o = 1'b1;
      SH_OTHERS: hit_o = (src_idx_i != MY_IDX);
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_TGT = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_TGT-1:0] cand_i,
  input  logic             adv_i,
  output logic [N_TGT-1:0] grant_o
);
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(N_TGT - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  // scan ptr+1 .. ptr+N, first candidate wins; no hit leaves ptr
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    ptr_d   = ptr_q;
    for (int k = 1; k <= N_TGT; k++) begin
      int p;
      p = (int'(ptr_q) + k) % N_TGT;
      if (!found && cand_i[p]) begin
        found      = 1'b1;
        grant_o[p] = 1'b1;
        ptr_d      = IDX_W'(p);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= PTR_RST;
    else if (adv_i) ptr_q <= ptr_d;
  end

  // R6
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cand_i == '0) |=> ptr_q == $past(ptr_q));

  // R5
  grant_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~cand_i) == '0);
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_match_pkg::*;
#(
  parameter int N_TGT = 4,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [31:0]        cmd_lo_i,
  input  logic [31:0]        cmd_hi_i,
  input  logic [IDX_W-1:0]   src_idx_i,
  input  logic [32*N_TGT-1:0] tgt_id_i,
  input  logic [8*N_TGT-1:0] tgt_log_id_i,
  input  logic [2*N_TGT-1:0] tgt_fmt_i,
  input  logic [N_TGT-1:0]   tgt_en_i,
  output logic [N_TGT-1:0]   deliver_o,
  output logic               done_o,
  output logic               fmt_err_o
);
  cmd_t             cmd;
  logic [N_TGT-1:0] hit, bad_fmt, grant;
  logic             lowest;

  assign cmd    = decode_cmd(cmd_lo_i, cmd_hi_i);
  assign lowest = (cmd.dmode == DM_LOWEST);

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    ipi_tgt_match #(.IDX_W(IDX_W), .TGT_IDX(g)) u_match (
      .cmd_i     (cmd),
      .src_idx_i (src_idx_i),
      .phys_id_i (tgt_id_i[32*g+24 +: 8]),
      .log_id_i  (tgt_log_id_i[8*g +: 8]),
      .fmt_i     (tgt_fmt_i[2*g +: 2]),
      .hit_o     (hit[g]),
      .bad_fmt_o (bad_fmt[g])
    );
  end

  ipi_rr_pick #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cand_i  (hit & tgt_en_i),
    .adv_i   (cmd_valid_i && lowest),
    .grant_o (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      deliver_o <= '0;
      fmt_err_o <= 1'b0;
    end else begin
      done_o    <= cmd_valid_i;
      deliver_o <= cmd_valid_i ? (lowest ? grant : hit) : '0;
      if (cmd_valid_i && |bad_fmt) fmt_err_o <= 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o && deliver_o == '0);
  // R5
  lowest_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && lowest) |=> $onehot0(deliver_o));
  // R5
  lowest_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && lowest) |=> (deliver_o & ~$past(tgt_en_i)) == '0);
  // R1
  phys_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowest && cmd.sh == SH_NONE && !cmd.logical && cmd.dest == 8'hFF)
      |=> &deliver_o);
  // R4
  sh_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowest && cmd.sh == SH_ALL) |=> &deliver_o);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> fmt_err_o);
endmodule

// File: tb/ipi_dest_match_test.sv
module ipi_dest_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [31:0]   cmd_lo = '0, cmd_hi = '0;
  logic [1:0]    src_idx = '0;
  logic [127:0]  tgt_id;
  logic [31:0]   tgt_log_id;
  logic [7:0]    tgt_fmt;
  logic [3:0]    tgt_en;
  logic [3:0]    deliver;
  logic          done, fmt_err;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dest_match #(.N_TGT(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid),
    .cmd_lo_i(cmd_lo), .cmd_hi_i(cmd_hi), .src_idx_i(src_idx),
    .tgt_id_i(tgt_id), .tgt_log_id_i(tgt_log_id), .tgt_fmt_i(tgt_fmt),
    .tgt_en_i(tgt_en), .deliver_o(deliver), .done_o(done), .fmt_err_o(fmt_err)
  );

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [1:0]  src;
    logic [3:0]  exp;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{32'h0000_0000, 32'h1200_0000, 2'd1, 4'b0100},  // R1 physical exact
    '{32'h0000_0000, 32'hFF00_0000, 2'd1, 4'b1111},  // R1 broadcast
    '{32'h0000_0000, 32'h5500_0000, 2'd1, 4'b0000},  // R1 no match
    '{32'h0000_0800, 32'h0500_0000, 2'd1, 4'b0101},  // R2 flat
    '{32'h0000_0800, 32'h0000_0000, 2'd1, 4'b0000},  // R2 flat zero
    '{32'h0004_0000, 32'h1200_0000, 2'd1, 4'b0010},  // R4 self
    '{32'h0008_0000, 32'h1200_0000, 2'd1, 4'b1111},  // R4 all
    '{32'h000C_0000, 32'h1200_0000, 2'd1, 4'b1101},  // R4 all but self
    '{32'h0004_0000, 32'h0000_0000, 2'd3, 4'b1000}   // R4 self, other source
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle strobe; result sampled at the following negedge
  task automatic send(input logic [31:0] lo, input logic [31:0] hi, input logic [1:0] src);
    @(negedge clk);
    cmd_lo = lo; cmd_hi = hi; src_idx = src; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic flat_cfg();
    tgt_log_id = {8'h08, 8'h04, 8'h02, 8'h01};
    tgt_fmt    = 8'b00_00_00_00;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tgt_id = {32'h1300_00AB, 32'h1200_00CD, 32'h1100_0012, 32'h1000_00FF};
    tgt_en = 4'b1111;
    flat_cfg();
    #(CLK_PERIOD * 2 + 3);
    chk("R10 done", 32'(done), 0);
    chk("R10 deliver", 32'(deliver), 0);
    chk("R10 err", 32'(fmt_err), 0);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      send(TBL[i].lo, TBL[i].hi, TBL[i].src);
      chk($sformatf("R1/R2/R4 vec%0d", i), 32'(deliver), 32'(TBL[i].exp));
    end

    // R9 pulse width
    send(32'h0, 32'h1100_0000, 2'd0);
    chk("R9 done high", 32'(done), 1);
    @(negedge clk);
    chk("R9 done low", 32'(done), 0);
    chk("R9 deliver idle", 32'(deliver), 0);

    // R7 enables ignored for fixed delivery
    tgt_en = 4'b0000;
    send(32'h0, 32'hFF00_0000, 2'd0);
    chk("R7 mask", 32'(deliver), 32'hF);
    tgt_en = 4'b1111;

    // R3 cluster
    tgt_log_id = {8'h23, 8'h31, 8'h22, 8'h21};
    tgt_fmt    = 8'b01_01_01_01;
    send(32'h800, 32'h2300_0000, 2'd0);
    chk("R3 cluster", 32'(deliver), 32'b1011);
    chk("R8 err clear", 32'(fmt_err), 0);

    // R8 invalid format on target 1
    tgt_fmt = 8'b01_01_10_01;
    send(32'h800, 32'h2300_0000, 2'd0);
    chk("R8 bad target skipped", 32'(deliver), 32'b1001);
    chk("R8 err set", 32'(fmt_err), 1);
    flat_cfg();
    send(32'h0, 32'h1000_0000, 2'd0);
    chk("R8 err sticky", 32'(fmt_err), 1);

    // R5 round robin from reset position
    for (int k = 0; k < 5; k++) begin
      send(32'h0008_0100, 32'h0, 2'd0);
      chk($sformatf("R5 rr step%0d", k), 32'(deliver), 32'(1 << (k % 4)));
    end
    tgt_en = 4'b0101;
    send(32'h0008_0100, 32'h0, 2'd0);
    chk("R5 skip disabled", 32'(deliver), 32'b0100);
    send(32'h0008_0100, 32'h0, 2'd0);
    chk("R5 wrap", 32'(deliver), 32'b0001);
    tgt_en = 4'b0000;
    send(32'h0008_0100, 32'h0, 2'd0);
    chk("R6 empty mask", 32'(deliver), 0);
    chk("R6 done", 32'(done), 1);
    tgt_en = 4'b1111;
    send(32'h0008_0100, 32'h0, 2'd0);
    chk("R6 ptr held", 32'(deliver), 32'b0010);
    send(32'h0000_0100, 32'h1300_0000, 2'd0);
    chk("R5 physical lowest", 32'(deliver), 32'b1000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule